// File: doc/BRIEF.md
# Serial Peripheral Slave With Pausable Select

This block is the slave end of a four-wire synchronous serial link. An external master supplies the bit clock, and the slave follows that clock only. The serial clock, the slave-in data line and an optional select line are each brought into the system clock domain through synchronizers. Edges are then detected from the synchronized clock. Any of the four clock polarity and phase combinations can be chosen, with either bit order and with a character length of seven or eight bits.

On the host side the block looks like a small register port. A one-entry transmit buffer holds the next outgoing character. That character moves into the transmit shift register while no frame is in progress, and from there it is driven on the slave-out line. Each completed incoming character lands in a receive buffer, which carries a ready flag and an overrun flag.

In the four-pin modes the select line gates the slave. While select is inactive, the output is released and clock edges are ignored. When select returns to its active level, the frame continues from the same bit it stopped at.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, rx_valid and rx_overrun are 0, tx_empty is 1 and rx_data is 0.
- R2: A tx_wr pulse makes tx_empty read 0 in the following cycle. If no frame is in progress, the character moves to the shift register and tx_empty returns to 1 within two cycles. A character written during a frame stays in the buffer, with tx_empty at 0, until that frame ends.
- R3: cfg_cpol=0 means the clock idles low and cfg_cpol=1 means it idles high. The leading edge of each bit is the first transition away from the idle level. With cfg_cpha=0, data is captured on the leading edge and changed on the trailing edge. With cfg_cpha=1, data is changed on the leading edge and captured on the trailing edge.
- R4: cfg_msb_first=1 sends and receives the most significant bit of the character first. cfg_msb_first=0 sends and receives the least significant bit first.
- R5: With cfg_seven_bit=1, a frame has 7 bits, bit 7 of tx_data is never sent, and bit 7 of rx_data is 0. With cfg_seven_bit=0, a frame has 8 bits.
- R6: After the last bit of a frame is captured, rx_data holds the character and rx_valid is 1. A rx_rd pulse clears rx_valid.
- R7: If a character is delivered while rx_valid is 1 and no rx_rd arrives in the same cycle, rx_overrun becomes 1 and rx_data holds the newest character. A rx_rd pulse clears rx_overrun.
- R8: The select mode is set by cfg_sel_mode. 2'b00 is three-pin: the select line is ignored and miso_oe stays 1. 2'b01 makes select active high. 2'b10 makes select active low. 2'b11 behaves as three-pin. While select is inactive, miso_oe is 0.
- R9: Clock edges seen while select is inactive are ignored. When select becomes active again, the frame resumes at the bit it had reached.
- R10: A frame that begins with no character in the transmit shift register sends all zeros.
- R11: With cfg_cpha=0, the first data bit is on miso_o before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Capture edge select: 0 leading, 1 trailing |
| cfg_msb_first | input | 1 | Bit order: 1 most significant bit first |
| cfg_seven_bit | input | 1 | Character length: 1 selects seven bits |
| cfg_sel_mode | input | 2 | Select handling: 00 none, 01 active high, 10 active low, 11 none |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| sel_i | input | 1 | Slave select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for miso_o |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DW | Character to transmit |
| tx_empty | output | 1 | Transmit buffer can accept a character |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DW | Last received character |
| rx_valid | output | 1 | Unread character in the receive buffer |
| rx_overrun | output | 1 | A character was overwritten before it was read |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is in progress, and that the system clock runs at least four times faster than the serial clock, so that every edge is seen on its own. The stimulus changes configuration only between frames. When it does, it first moves the serial clock to its new idle level and lets the synchronizers settle, so the idle-level change reaches the slave as a trailing-type transition, which the slave ignores. Each serial half period lasts eight system cycles. Data and select change either together with a clock edge that the slave must ignore, or a full half period away from the edges the slave acts on.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_HIGH = 2'b01,
        SEL_LOW  = 2'b10,
        SEL_RSVD = 2'b11
    } sel_mode_e;

endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign st_d[g] = din;
        end else begin : g_next
            assign st_d[g] = st_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[g] <= '0;
            else        st_q[g] <= st_d[g];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/spi_sel_edge.sv
module spi_sel_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic sclk_s,
    output logic lead_ev,
    output logic trail_ev
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d   = sclk_s;
        rise     = sclk_s & ~prev_q;
        fall     = ~sclk_s & prev_q;
        // Leading edge leaves the idle level.
        lead_ev  = cpol ? fall : rise;
        trail_ev = cpol ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi_sel_shift.sv
module spi_sel_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_cpha,
    input  logic          cfg_msb_first,
    input  logic          cfg_seven_bit,
    input  logic          active,
    input  logic          lead_ev,
    input  logic          trail_ev,
    input  logic          mosi_s,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic          tx_empty,
    output logic          miso_bit,
    output logic          rx_done,
    output logic [DW-1:0] rx_char
);
    localparam int CW = $clog2(2 * DW + 1);

    typedef struct packed {
        logic [DW-1:0] tx_buf;
        logic          tx_full;
        logic [DW-1:0] tx_sh;
        logic [DW-1:0] rx_sh;
        logic [CW-1:0] e_cnt;
        logic          out_bit;
        logic          rx_done;
        logic [DW-1:0] rx_char;
    } sh_state_t;

    sh_state_t     d, q;
    logic [CW-1:0] nbits;
    logic [DW-1:0] char_mask;
    logic [DW-1:0] rx_next;
    logic          cur_bit, lead_slot, step, capture;

    always_comb begin
        d         = q;
        d.rx_done = 1'b0;
        nbits     = cfg_seven_bit ? CW'(DW - 1) : CW'(DW);
        char_mask = cfg_seven_bit ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
        cur_bit   = cfg_msb_first ? (cfg_seven_bit ? q.tx_sh[DW-2] : q.tx_sh[DW-1])
                                  : q.tx_sh[0];
        // Even counts wait for a leading edge, odd counts for a trailing edge.
        lead_slot = ~q.e_cnt[0];
        step      = active && ((lead_slot && lead_ev) || (!lead_slot && trail_ev));
        capture   = step && (lead_slot != cfg_cpha);

        if (cfg_msb_first)      rx_next = {q.rx_sh[DW-2:0], mosi_s} & char_mask;
        else if (cfg_seven_bit) rx_next = {1'b0, mosi_s, q.rx_sh[DW-2:1]};
        else                    rx_next = {mosi_s, q.rx_sh[DW-1:1]};

        // Reload only before the first edge of a frame.
        if (q.e_cnt == '0 && !step && q.tx_full) begin
            d.tx_sh   = q.tx_buf;
            d.tx_full = 1'b0;
        end

        if (capture) begin
            d.rx_sh = rx_next;
            if ((q.e_cnt >> 1) == nbits - 1'b1) begin
                d.rx_done = 1'b1;
                d.rx_char = rx_next;
            end
        end

        if (step && !capture) begin
            d.out_bit = cur_bit;
            d.tx_sh   = cfg_msb_first ? (q.tx_sh << 1) : (q.tx_sh >> 1);
        end

        if (step) begin
            d.e_cnt = q.e_cnt + 1'b1;
            if (d.e_cnt == (nbits << 1)) begin
                d.e_cnt   = '0;
                d.tx_sh   = '0;
                d.out_bit = 1'b0;
            end
        end

        if (tx_wr) begin
            d.tx_buf  = tx_data & char_mask;
            d.tx_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_empty = ~q.tx_full;
    assign miso_bit = cfg_cpha ? q.out_bit : cur_bit;
    assign rx_done  = q.rx_done;
    assign rx_char  = q.rx_char;

    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    p_pause_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(q.e_cnt));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.e_cnt < CW'(2 * DW));

    p_seven_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && cfg_seven_bit) |-> !rx_char[DW-1]);
endmodule

// File: rtl/spi_sel_rxbuf.sv
module spi_sel_rxbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_char,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_overrun
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
        logic          ovr;
    } rb_state_t;

    rb_state_t d, q;

    always_comb begin
        d = q;
        if (rx_rd) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end
        if (rx_done) begin
            d.data  = rx_char;
            d.valid = 1'b1;
            if (q.valid && !rx_rd) d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data    = q.data;
    assign rx_valid   = q.valid;
    assign rx_overrun = q.ovr;

    p_done_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_valid);

    p_overrun_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_valid && !rx_rd) |=> rx_overrun);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_done) |=> (!rx_valid && !rx_overrun));
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_msb_first,
    input  logic          cfg_seven_bit,
    input  logic [1:0]    cfg_sel_mode,
    input  logic          sclk_i,
    input  logic          mosi_i,
    input  logic          sel_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic          tx_empty,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_overrun
);
    import spi_sel_pkg::*;

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] pins_s;
    logic             sclk_s, mosi_s, sel_s;
    logic             lead_ev, trail_ev;
    logic             active, miso_bit;
    logic             rx_done;
    logic [DW-1:0]    rx_char;
    sel_mode_e        mode;

    spi_sel_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_i, mosi_i, sclk_i}),
        .dout (pins_s)
    );

    assign {sel_s, mosi_s, sclk_s} = pins_s;
    assign mode = sel_mode_e'(cfg_sel_mode);

    always_comb begin
        case (mode)
            SEL_HIGH: active = sel_s;
            SEL_LOW:  active = ~sel_s;
            default:  active = 1'b1;
        endcase
    end

    spi_sel_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpol    (cfg_cpol),
        .sclk_s  (sclk_s),
        .lead_ev (lead_ev),
        .trail_ev(trail_ev)
    );

    spi_sel_shift #(.DW(DW)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_cpha     (cfg_cpha),
        .cfg_msb_first(cfg_msb_first),
        .cfg_seven_bit(cfg_seven_bit),
        .active       (active),
        .lead_ev      (lead_ev),
        .trail_ev     (trail_ev),
        .mosi_s       (mosi_s),
        .tx_wr        (tx_wr),
        .tx_data      (tx_data),
        .tx_empty     (tx_empty),
        .miso_bit     (miso_bit),
        .rx_done      (rx_done),
        .rx_char      (rx_char)
    );

    spi_sel_rxbuf #(.DW(DW)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_done   (rx_done),
        .rx_char   (rx_char),
        .rx_rd     (rx_rd),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_overrun(rx_overrun)
    );

    assign miso_oe = active;
    assign miso_o  = active & miso_bit;
endmodule

// File: tb/spi_sel_slave_tb.sv
module spi_sel_slave_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 0, cfg_cpha = 0, cfg_msb_first = 0, cfg_seven_bit = 0;
    logic [1:0] cfg_sel_mode = 2'b00;
    logic       sclk_i = 0, mosi_i = 0, sel_i = 0;
    logic       miso_o, miso_oe;
    logic       tx_wr = 0;
    logic [7:0] tx_data = '0;
    logic       tx_empty;
    logic       rx_rd = 0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_overrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_sel_slave u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_msb_first(cfg_msb_first),
        .cfg_seven_bit(cfg_seven_bit), .cfg_sel_mode(cfg_sel_mode),
        .sclk_i(sclk_i), .mosi_i(mosi_i), .sel_i(sel_i),
        .miso_o(miso_o), .miso_oe(miso_oe),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_overrun(rx_overrun)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wt(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic four_pin();
        return (cfg_sel_mode == 2'b01) || (cfg_sel_mode == 2'b10);
    endfunction

    function automatic logic sel_level(input logic act);
        if (cfg_sel_mode == 2'b01) return act;
        if (cfg_sel_mode == 2'b10) return !act;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_char(input logic [7:0] v);
        return cfg_seven_bit ? (v & 8'h7F) : v;
    endfunction

    task automatic set_cfg(input logic pol, input logic pha, input logic msb,
                           input logic sev, input logic [1:0] md);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_msb_first = msb;
        cfg_seven_bit = sev; cfg_sel_mode = md;
        wt(1);
        sclk_i = pol;
        sel_i  = sel_level(1'b0);
        wt(6);
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk);
        tx_wr = 1; tx_data = v;
        @(negedge clk);
        tx_wr = 0;
        check("R2 buffer full after write", {7'd0, tx_empty}, 8'd0);
        wt(2);
        check("R2 moved to shift register", {7'd0, tx_empty}, 8'd1);
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
        check("R6 read clears valid", {7'd0, rx_valid}, 8'd0);
        check("R7 read clears overrun", {7'd0, rx_overrun}, 8'd0);
    endtask

    task automatic run_frame(input logic [7:0] m, input int pause_at, input int wr_at,
                             input logic [7:0] wr_val, output logic [7:0] got);
        int n;
        logic [7:0] bits;
        n = cfg_seven_bit ? 7 : 8;
        bits = '0;
        got = '0;
        if (four_pin()) begin
            sel_i = sel_level(1'b1);
            wt(H);
        end
        for (int i = 0; i < n; i++) begin
            if (i == pause_at && four_pin()) begin
                wt(H);
                sel_i = sel_level(1'b0);
                wt(H);
                check("R8 output released while inactive", {7'd0, miso_oe}, 8'd0);
                sclk_i = ~cfg_cpol; mosi_i = ~mosi_i;
                wt(H);
                sclk_i = cfg_cpol;
                wt(H);
                sel_i = sel_level(1'b1);
                wt(H);
            end
            if (i == wr_at) begin
                @(negedge clk);
                tx_wr = 1; tx_data = wr_val;
                @(negedge clk);
                tx_wr = 0;
                wt(2);
                check("R2 held in buffer during frame", {7'd0, tx_empty}, 8'd0);
            end
            if (!cfg_cpha) begin
                mosi_i = cfg_msb_first ? m[n-1-i] : m[i];
                wt(H);
                check("R8 output enabled", {7'd0, miso_oe}, 8'd1);
                bits[i] = miso_o;
                sclk_i = ~cfg_cpol;
                wt(H);
                sclk_i = cfg_cpol;
            end else begin
                sclk_i = ~cfg_cpol;
                mosi_i = cfg_msb_first ? m[n-1-i] : m[i];
                wt(H);
                check("R8 output enabled", {7'd0, miso_oe}, 8'd1);
                bits[i] = miso_o;
                sclk_i = cfg_cpol;
                wt(H);
            end
        end
        wt(H);
        if (four_pin()) begin
            sel_i = sel_level(1'b0);
            wt(4);
        end
        for (int i = 0; i < n; i++) begin
            if (cfg_msb_first) got[n-1-i] = bits[i];
            else               got[i] = bits[i];
        end
    endtask

    initial begin
        logic [7:0] got, tx, m;
        void'($urandom(32'h5EED_1234));
        wt(5);
        check("R1 rx_valid reset", {7'd0, rx_valid}, 8'd0);
        check("R1 rx_overrun reset", {7'd0, rx_overrun}, 8'd0);
        check("R1 tx_empty reset", {7'd0, tx_empty}, 8'd1);
        check("R1 rx_data reset", rx_data, 8'd0);
        @(negedge clk);
        rst_n = 1;
        wt(4);

        // Mode 0, MSB first, 8-bit.
        set_cfg(0, 0, 1, 0, 2'b00);
        load_tx(8'hA5);
        run_frame(8'h3C, -1, -1, 8'h00, got);
        check("R3 R4 miso char cpol0 cpha0 msb", got, 8'hA5);
        check("R6 rx_data", rx_data, 8'h3C);
        check("R6 rx_valid", {7'd0, rx_valid}, 8'd1);
        read_rx();

        // Empty shift register and a write during the frame.
        set_cfg(1, 1, 0, 0, 2'b00);
        run_frame(8'h81, -1, 2, 8'h96, got);
        check("R10 empty frame sends zeros", got, 8'h00);
        wt(2);
        check("R2 moved after frame end", {7'd0, tx_empty}, 8'd1);
        read_rx();
        run_frame(8'h42, -1, -1, 8'h00, got);
        check("R2 late write sent next frame", got, 8'h96);
        check("R4 lsb-first receive", rx_data, 8'h42);

        // Overrun: second frame without a read.
        run_frame(8'h17, -1, -1, 8'h00, got);
        check("R7 overrun set", {7'd0, rx_overrun}, 8'd1);
        check("R7 newest char kept", rx_data, 8'h17);
        read_rx();

        // Seven-bit mode.
        set_cfg(0, 1, 1, 1, 2'b00);
        load_tx(8'hFF);
        run_frame(8'hFF, -1, -1, 8'h00, got);
        check("R5 bit 7 of tx not sent", got, 8'h7F);
        check("R5 rx bit 7 zero", rx_data, 8'h7F);
        read_rx();

        // Four-pin active high, phase 0: first bit before first edge.
        set_cfg(0, 0, 1, 0, 2'b01);
        check("R8 inactive releases output", {7'd0, miso_oe}, 8'd0);
        load_tx(8'h80);
        run_frame(8'h5A, -1, -1, 8'h00, got);
        check("R11 first bit driven before first edge", got, 8'h80);
        check("R8 active-high receive", rx_data, 8'h5A);
        read_rx();

        // Four-pin active low with a pause mid-frame.
        set_cfg(1, 1, 0, 0, 2'b10);
        load_tx(8'hC3);
        run_frame(8'h6E, 3, -1, 8'h00, got);
        check("R9 tx resumes after pause", got, 8'hC3);
        check("R9 rx resumes after pause", rx_data, 8'h6E);
        read_rx();
        set_cfg(0, 0, 0, 1, 2'b01);
        load_tx(8'h2B);
        run_frame(8'h55, 5, -1, 8'h00, got);
        check("R9 pause phase 0 tx", got, 8'h2B);
        check("R9 pause phase 0 rx", rx_data, 8'h55);
        read_rx();

        // Reserved mode behaves as three-pin.
        set_cfg(0, 0, 0, 0, 2'b11);
        sel_i = 1; wt(4);
        check("R8 mode 11 drives with select high", {7'd0, miso_oe}, 8'd1);
        sel_i = 0; wt(4);
        check("R8 mode 11 drives with select low", {7'd0, miso_oe}, 8'd1);

        // Random configurations.
        for (int k = 0; k < 24; k++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, 2'($urandom % 4));
            tx = 8'($urandom);
            m  = 8'($urandom);
            load_tx(tx);
            run_frame(m, (k % 3 == 0) ? 1 + (k % 5) : -1, -1, 8'h00, got);
            check("R3 R4 random tx char", got, exp_char(tx));
            check("R6 random rx char", rx_data, exp_char(m));
            check("R6 random rx_valid", {7'd0, rx_valid}, 8'd1);
            check("R7 no overrun after read", {7'd0, rx_overrun}, 8'd0);
            read_rx();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule